// File: doc/BRIEF.md
# GPIO Port Direction Priority Mux

This block owns one 8-bit general-purpose I/O port. It holds a bus-writable direction register and a data register, and it decides for every pin whether the pad drives, listens, or is fully isolated. Each pin applies its own fixed chain of peripheral overrides. An LCD segment enable ranks above everything else and switches off both pad buffers. On some pins the IIC, the SPI or a clock output may take the pin next. When none of them claims the pin, the direction register decides.

Pad levels come back through a two-flop synchronizer. A port read returns the synchronized level for an input pin, the data register bit for an output pin, and 0 for a pin held by LCD. A second read select returns the direction register. The pad output data always comes from the data register. The IIC, SPI and LCD engines sit outside this block and only supply enables and direction requests.

Top module: `gpio_dir_mux`

## Requirements
- R1: After reset the direction and data registers read 0, every `pad_oe` bit is 0 and, with no LCD enable, every `pad_ie` bit is 1.
- R2: With no override on a pin, direction bit 1 sets `pad_oe` for that pin and 0 clears it. `pad_do` always equals the data register. A write with `wr_sel`=0 targets the data register and `wr_sel`=1 targets the direction register.
- R3: When `lcd_en[i]` is 1, `pad_oe[i]` and `pad_ie[i]` are both 0 and port read bit i is 0, whatever the other inputs are.
- R4: On pins 3 and 0, when `iic_en` and `iic_route` are both 1 and LCD is off, the output enable follows `iic_dir` (bit 1 for pin 3, bit 0 for pin 0). This ranks above the SPI and the direction register.
- R5: On pins 3 to 0, when `spi_en` and `spi_route` are both 1 and no higher override applies, the output enable follows `spi_dir[i]`.
- R6: On pin 2, when `clkout_en` is 1 and neither LCD nor SPI owns the pin, `pad_oe[2]` is 1 even if the direction bit is 0.
- R7: Pins 7 to 4 ignore the IIC, SPI and clock-output controls and follow the direction register only.
- R8: A port read of an input pin (read select `rd_sel`=0) returns the pad level from two clock edges earlier. A change on `pad_di` shows up after the second rising edge and not after the first.
- R9: A port read of an output pin returns the data register bit, not the pad level.
- R10: A read with `rd_sel`=1 returns the value last written to the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | write target: 0 data, 1 direction |
| wr_data | input | 8 | write value |
| rd_sel | input | 1 | read source: 0 port, 1 direction |
| rd_data | output | 8 | read value |
| lcd_en | input | 8 | per-pin LCD segment enable |
| iic_en | input | 1 | IIC enabled |
| iic_route | input | 1 | IIC routed to this port |
| iic_dir | input | 2 | IIC direction request: bit 1 pin 3, bit 0 pin 0 |
| spi_en | input | 1 | SPI enabled |
| spi_route | input | 1 | SPI routed to this port |
| spi_dir | input | 4 | SPI direction request for pins 3..0 |
| clkout_en | input | 1 | clock output enabled on pin 2 |
| pad_di | input | 8 | pad input levels |
| pad_oe | output | 8 | pad output enable |
| pad_ie | output | 8 | pad input enable |
| pad_do | output | 8 | pad output data |

## Verification
Direction, enables, `pad_do` and the read mux are combinational from registers and control inputs. A register write therefore shows up on the ports right after the rising edge that takes it, and control changes show up at once. Pad input levels need two rising edges before a read returns them. The bench drives everything on the falling edge and samples on a later falling edge. For the synchronizer it checks once after one rising edge, where the old value is expected, and once after the second, where the new value is expected.

// File: rtl/gpio_dir_mux.sv
module gpio_dir_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  input  logic [7:0] lcd_en,
  input  logic       iic_en,
  input  logic       iic_route,
  input  logic [1:0] iic_dir,
  input  logic       spi_en,
  input  logic       spi_route,
  input  logic [3:0] spi_dir,
  input  logic       clkout_en,
  input  logic [7:0] pad_di,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_ie,
  output logic [7:0] pad_do
);
  logic [7:0] ddr_q, dat_q, sync1_q, sync2_q, dir, pin_rd;
  logic       iic_own, spi_own;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ddr_q <= '0;
      dat_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) ddr_q <= wr_data;
      else        dat_q <= wr_data;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_di;
      sync2_q <= sync1_q;
    end

  assign iic_own = iic_en & iic_route;
  assign spi_own = spi_en & spi_route;

  assign dir[7:4] = ddr_q[7:4];
  assign dir[3] = iic_own ? iic_dir[1] : spi_own ? spi_dir[3] : ddr_q[3];
  assign dir[2] = spi_own ? spi_dir[2] : clkout_en ? 1'b1 : ddr_q[2];
  assign dir[1] = spi_own ? spi_dir[1] : ddr_q[1];
  assign dir[0] = iic_own ? iic_dir[0] : spi_own ? spi_dir[0] : ddr_q[0];

  assign pad_oe = dir & ~lcd_en;
  assign pad_ie = ~lcd_en;
  assign pad_do = dat_q;

  assign pin_rd  = ~lcd_en & ((pad_oe & dat_q) | (~pad_oe & sync2_q));
  assign rd_data = rd_sel ? ddr_q : pin_rd;
endmodule

module gpio_dir_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_sel,
  input logic [7:0] rd_data,
  input logic [7:0] lcd_en,
  input logic       iic_en,
  input logic       iic_route,
  input logic [1:0] iic_dir,
  input logic       spi_en,
  input logic       spi_route,
  input logic [3:0] spi_dir,
  input logic       clkout_en,
  input logic [7:0] pad_di,
  input logic [7:0] pad_oe,
  input logic [7:0] pad_ie,
  input logic [7:0] pad_do
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  a_r3_lcd_isolates: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & lcd_en) == 8'h00) && ((pad_ie & lcd_en) == 8'h00));
  a_r3_lcd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> ((rd_data & lcd_en) == 8'h00));
  a_r4_iic_pin3: assert property (@(posedge clk) disable iff (!rst_n)
    (iic_en && iic_route && !lcd_en[3]) |-> (pad_oe[3] == iic_dir[1]));
  a_r4_iic_pin0: assert property (@(posedge clk) disable iff (!rst_n)
    (iic_en && iic_route && !lcd_en[0]) |-> (pad_oe[0] == iic_dir[0]));
  a_r5_spi_pin1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_route && !lcd_en[1]) |-> (pad_oe[1] == spi_dir[1]));
  a_r6_clkout_pin2: assert property (@(posedge clk) disable iff (!rst_n)
    (clkout_en && !lcd_en[2] && !(spi_en && spi_route)) |-> pad_oe[2]);
  a_r8_sync_pin7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && !rd_sel && !lcd_en[7] && !pad_oe[7]) |-> (rd_data[7] == $past(pad_di[7], 2)));
  a_r9_out_readback: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> ((rd_data & pad_oe) == (pad_do & pad_oe)));
endmodule

bind gpio_dir_mux gpio_dir_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data), .lcd_en(lcd_en),
  .iic_en(iic_en), .iic_route(iic_route), .iic_dir(iic_dir), .spi_en(spi_en),
  .spi_route(spi_route), .spi_dir(spi_dir), .clkout_en(clkout_en), .pad_di(pad_di),
  .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_do(pad_do)
);

// File: tb/gpio_dir_mux_bench.sv
module gpio_dir_mux_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0, lcd_en = 0, pad_di = 0;
  logic iic_en = 0, iic_route = 0, spi_en = 0, spi_route = 0, clkout_en = 0;
  logic [1:0] iic_dir = 0;
  logic [3:0] spi_dir = 0;
  logic [7:0] rd_data, pad_oe, pad_ie, pad_do;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_dir_mux u_gpio_dir_mux (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 oe", pad_oe, 8'h00);
    check("R1 ie", pad_ie, 8'hFF);
    rd_sel = 1; #1; check("R1 ddr", rd_data, 8'h00); rd_sel = 0;
    check("R1 data", pad_do, 8'h00);
  endtask

  task automatic t_ddr;
    wr(1, 8'hA5); wr(0, 8'h3C);
    check("R2 oe", pad_oe, 8'hA5);
    check("R2 do", pad_do, 8'h3C);
    rd_sel = 1; #1; check("R10 ddr read", rd_data, 8'hA5); rd_sel = 0;
  endtask

  task automatic t_lcd;
    wr(1, 8'hFF); wr(0, 8'hFF);
    @(negedge clk); lcd_en = 8'h81; clkout_en = 1; iic_en = 1; iic_route = 1; iic_dir = 2'b11; #1;
    check("R3 oe", pad_oe, 8'h7E);
    check("R3 ie", pad_ie, 8'h7E);
    check("R3 read", rd_data & 8'h81, 8'h00);
    lcd_en = 0; clkout_en = 0; iic_en = 0; iic_route = 0; iic_dir = 0;
  endtask

  task automatic t_iic;
    wr(1, 8'h00);
    @(negedge clk); spi_en = 1; spi_route = 1; spi_dir = 4'hF;
    iic_en = 1; iic_route = 1; iic_dir = 2'b10; #1;
    check("R4 iic over spi", pad_oe & 8'h0F, 8'h0E);
    iic_route = 0; #1;
    check("R5 spi when iic unrouted", pad_oe & 8'h0F, 8'h0F);
    spi_dir = 4'h5; #1;
    check("R5 spi dir", pad_oe & 8'h0F, 8'h05);
    spi_route = 0; #1;
    check("R5 spi unrouted", pad_oe, 8'h00);
    spi_en = 0; iic_en = 0; spi_dir = 0; iic_dir = 0;
  endtask

  task automatic t_clkout;
    wr(1, 8'h00);
    @(negedge clk); clkout_en = 1; #1;
    check("R6 clkout", pad_oe, 8'h04);
    spi_en = 1; spi_route = 1; spi_dir = 4'h0; #1;
    check("R6 spi above clkout", pad_oe, 8'h00);
    spi_en = 0; spi_route = 0; clkout_en = 0;
  endtask

  task automatic t_upper;
    wr(1, 8'h50);
    @(negedge clk); iic_en = 1; iic_route = 1; iic_dir = 2'b11;
    spi_en = 1; spi_route = 1; spi_dir = 4'hF; clkout_en = 1; #1;
    check("R7 upper ignore", pad_oe & 8'hF0, 8'h50);
    iic_en = 0; iic_route = 0; iic_dir = 0; spi_en = 0; spi_route = 0; spi_dir = 0; clkout_en = 0;
  endtask

  task automatic t_sync;
    wr(1, 8'h00);
    @(negedge clk); pad_di = 8'h00;
    @(negedge clk); @(negedge clk);
    pad_di = 8'h96;
    @(negedge clk); check("R8 one edge old", rd_data, 8'h00);
    @(negedge clk); check("R8 two edges new", rd_data, 8'h96);
  endtask

  task automatic t_readback;
    wr(0, 8'h0F); wr(1, 8'hF0);
    @(negedge clk); check("R9 mix", rd_data, 8'h06);
    pad_di = 8'h69; @(negedge clk); @(negedge clk);
    check("R9 outputs keep data", rd_data, 8'h09);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_ddr; t_lcd; t_iic; t_clkout; t_upper; t_sync; t_readback;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule